// File: doc/BRIEF.md
# Per-Pin Interrupt Detector for an Eight-Pin Port

This block watches the input pins of a port and turns selected pin activity into sticky per-pin flags and a single interrupt request. Each pin has its own settings. One bit chooses edge or level detection. Another bit chooses the active edge or level. A third bit makes the pin respond to any transition, and this overrides the first two. A fourth bit sends the pin through a three-stage synchronizer before detection. An enable bit decides whether the pin's flag reaches the request line.

Software reaches the block over a plain 32-bit register bus. Writes take effect on the next clock edge, and read data depends only on the address. Flags are read at one address. They are cleared by writing ones to a separate clear address. Bit i of every register belongs to pin i.

Top module: `gid_top`

## Requirements
- R1: The register map uses byte offsets. 0x10 is enable, 0x20 is type, 0x24 is polarity, 0x28 is both-edge and 0x2C is sync; each reads back its low 8 bits as written, with the upper bits read as 0. Offset 0x14 returns the flags and ignores writes. Offset 0x1C reads as 0. Any other offset reads as 0.
- R2: With the pin's sync bit at 0, the pin is sampled once, and a qualifying change shows in the flag and request after the second rising clock edge that follows the change.
- R3: With the pin's sync bit at 1, the sample passes through three flops, and the flag appears after the fourth rising clock edge that follows the change.
- R4: With type bit 0 (edge), polarity 1 flags on rising edges only and polarity 0 flags on falling edges only.
- R5: With type bit 1 (level), the flag is set on every cycle that the sampled pin equals the polarity bit. A clear written while the level is active leaves the flag set, and the flag stays set after the level goes away.
- R6: A both-edge bit of 1 makes the pin flag on rising and on falling edges, whatever its type and polarity bits hold.
- R7: A flag stays set until a write to 0x1C has a 1 in that pin's bit. Zero bits in that write leave their flags unchanged.
- R8: An event and a clear on the same pin in the same cycle leave the flag set.
- R9: The request output is the OR over all pins of flag AND enable. Flags still record events when the enable bit is 0.
- R10: After reset, every register and flag is 0 and the request is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | 8 | Port input pins |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| irq_out | output | 1 | Combined interrupt request |

## Verification
The sampling assertions assume the pins are stable around the clock edge. They also assume the configuration is not changed while the pin they describe is moving. This is because switching a pin's sync or mode bits can produce a single spurious event. The stimulus changes pins only on falling clock edges. Every configuration write is followed by a settling period and a full clear before a new pin waveform starts, so no flag carried over from a mode change reaches a check.

// File: rtl/gid_pkg.sv
package gid_pkg;

    localparam int GID_ADDR_W = 6;

    localparam logic [GID_ADDR_W-1:0] OFF_ENABLE = 6'h10;
    localparam logic [GID_ADDR_W-1:0] OFF_FLAGS  = 6'h14;
    localparam logic [GID_ADDR_W-1:0] OFF_CLEAR  = 6'h1C;
    localparam logic [GID_ADDR_W-1:0] OFF_KIND   = 6'h20;
    localparam logic [GID_ADDR_W-1:0] OFF_POL    = 6'h24;
    localparam logic [GID_ADDR_W-1:0] OFF_ANYEDG = 6'h28;
    localparam logic [GID_ADDR_W-1:0] OFF_SYNC   = 6'h2C;

    typedef enum logic {
        DET_EDGE  = 1'b0,
        DET_LEVEL = 1'b1
    } det_kind_t;

    typedef struct packed {
        det_kind_t kind;
        logic      pol;
        logic      any_edge;
    } det_mode_t;

    // Event for one pin from its current and previous sample.
    function automatic logic pin_event(det_mode_t m, logic cur, logic prv);
        logic rise;
        logic fall;
        rise = cur & ~prv;
        fall = ~cur & prv;
        if (m.any_edge)
            return rise | fall;
        if (m.kind == DET_LEVEL)
            return cur == m.pol;
        return m.pol ? rise : fall;
    endfunction

endpackage

// File: rtl/gid_regs.sv
module gid_regs
    import gid_pkg::*;
#(
    parameter int N_PINS = 8,
    parameter int DATA_W = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr,
    input  logic [GID_ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0]     wdata,
    input  logic [N_PINS-1:0]     flags,
    output logic [DATA_W-1:0]     rdata,
    output logic [N_PINS-1:0]     en_vec,
    output logic [N_PINS-1:0]     sync_vec,
    output det_mode_t [N_PINS-1:0] mode,
    output logic [N_PINS-1:0]     clr_mask
);

    localparam int PAD_W = DATA_W - N_PINS;

    logic [N_PINS-1:0] en_q, kind_q, pol_q, any_q, sync_q;
    logic              unused_wdata_hi;

    assign unused_wdata_hi = ^wdata[DATA_W-1:N_PINS];

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= '0;
            kind_q <= '0;
            pol_q  <= '0;
            any_q  <= '0;
            sync_q <= '0;
        end else if (wr) begin
            case (addr)
                OFF_ENABLE: en_q   <= wdata[N_PINS-1:0];
                OFF_KIND:   kind_q <= wdata[N_PINS-1:0];
                OFF_POL:    pol_q  <= wdata[N_PINS-1:0];
                OFF_ANYEDG: any_q  <= wdata[N_PINS-1:0];
                OFF_SYNC:   sync_q <= wdata[N_PINS-1:0];
                default: ;
            endcase
        end
    end

    assign clr_mask = (wr && addr == OFF_CLEAR) ? wdata[N_PINS-1:0] : '0;
    assign en_vec   = en_q;
    assign sync_vec = sync_q;

    for (genvar i = 0; i < N_PINS; i++) begin : g_mode
        assign mode[i].kind     = det_kind_t'(kind_q[i]);
        assign mode[i].pol      = pol_q[i];
        assign mode[i].any_edge = any_q[i];
    end

    always_comb begin
        case (addr)
            OFF_ENABLE: rdata = {{PAD_W{1'b0}}, en_q};
            OFF_FLAGS:  rdata = {{PAD_W{1'b0}}, flags};
            OFF_KIND:   rdata = {{PAD_W{1'b0}}, kind_q};
            OFF_POL:    rdata = {{PAD_W{1'b0}}, pol_q};
            OFF_ANYEDG: rdata = {{PAD_W{1'b0}}, any_q};
            OFF_SYNC:   rdata = {{PAD_W{1'b0}}, sync_q};
            default:    rdata = '0;
        endcase
    end

endmodule

// File: rtl/gid_sampler.sv
module gid_sampler #(
    parameter int N_PINS     = 8,
    parameter int SYNC_DEPTH = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_PINS-1:0] pin,
    input  logic [N_PINS-1:0] sync_sel,
    output logic [N_PINS-1:0] samp
);

    logic [1:0] age_q;

    always_ff @(posedge clk) begin
        if (rst)
            age_q <= '0;
        else if (age_q != 2'd3)
            age_q <= age_q + 2'd1;
    end

    for (genvar i = 0; i < N_PINS; i++) begin : g_pin
        logic [SYNC_DEPTH-1:0] chain_q;

        always_ff @(posedge clk) begin
            if (rst)
                chain_q <= '0;
            else
                chain_q <= {chain_q[SYNC_DEPTH-2:0], pin[i]};
        end

        assign samp[i] = sync_sel[i] ? chain_q[SYNC_DEPTH-1] : chain_q[0];

        a_r2_raw_sample: assert property (@(posedge clk) disable iff (rst || age_q == 2'd0)
            !sync_sel[i] |-> samp[i] == $past(pin[i]));

        if (SYNC_DEPTH == 3) begin : g_sync_chk
            a_r3_sync_sample: assert property (@(posedge clk) disable iff (rst || age_q != 2'd3)
                sync_sel[i] |-> samp[i] == $past(pin[i], 3));
        end
    end

endmodule

// File: rtl/gid_detect.sv
module gid_detect
    import gid_pkg::*;
#(
    parameter int N_PINS = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [N_PINS-1:0]      samp,
    input  det_mode_t [N_PINS-1:0] mode,
    input  logic [N_PINS-1:0]      clr_mask,
    output logic [N_PINS-1:0]      flags
);

    logic [N_PINS-1:0] prev_q, flag_q, evt;

    always_comb begin
        for (int i = 0; i < N_PINS; i++)
            evt[i] = pin_event(mode[i], samp[i], prev_q[i]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            flag_q <= '0;
        end else begin
            prev_q <= samp;
            flag_q <= evt | (flag_q & ~clr_mask);
        end
    end

    assign flags = flag_q;

    for (genvar i = 0; i < N_PINS; i++) begin : g_chk
        a_r8_event_sets: assert property (@(posedge clk) disable iff (rst)
            evt[i] |=> flag_q[i]);
        a_r7_clear_takes: assert property (@(posedge clk) disable iff (rst)
            (clr_mask[i] && !evt[i]) |=> !flag_q[i]);
        a_r7_flag_holds: assert property (@(posedge clk) disable iff (rst)
            (flag_q[i] && !clr_mask[i]) |=> flag_q[i]);
    end

endmodule

// File: rtl/gid_top.sv
module gid_top
    import gid_pkg::*;
#(
    parameter int N_PINS     = 8,
    parameter int DATA_W     = 32,
    parameter int SYNC_DEPTH = 3
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [N_PINS-1:0]     pin_in,
    input  logic                  reg_wr,
    input  logic [GID_ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0]     reg_wdata,
    output logic [DATA_W-1:0]     reg_rdata,
    output logic                  irq_out
);

    logic [N_PINS-1:0]      en_vec, sync_vec, clr_mask, samp, flags;
    det_mode_t [N_PINS-1:0] mode;

    gid_regs #(.N_PINS(N_PINS), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
        .flags(flags), .rdata(reg_rdata), .en_vec(en_vec), .sync_vec(sync_vec),
        .mode(mode), .clr_mask(clr_mask)
    );

    gid_sampler #(.N_PINS(N_PINS), .SYNC_DEPTH(SYNC_DEPTH)) u_samp (
        .clk(clk), .rst(rst), .pin(pin_in), .sync_sel(sync_vec), .samp(samp)
    );

    gid_detect #(.N_PINS(N_PINS)) u_det (
        .clk(clk), .rst(rst), .samp(samp), .mode(mode), .clr_mask(clr_mask),
        .flags(flags)
    );

    assign irq_out = |(flags & en_vec);

    a_r9_irq_needs_enable: assert property (@(posedge clk) disable iff (rst)
        (en_vec == '0) |-> !irq_out);

endmodule

// File: tb/tb_gid_top.sv
`timescale 1ns/1ps
module tb_gid_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  pin_in = 8'h00;
    logic        reg_wr = 1'b0;
    logic [5:0]  reg_addr = 6'h14;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_out;

    int n_chk = 0;
    int n_fail = 0;

    localparam logic [5:0] A_EN = 6'h10, A_FLG = 6'h14, A_CLR = 6'h1C,
                           A_TYP = 6'h20, A_POL = 6'h24, A_ANY = 6'h28, A_SYN = 6'h2C;

    always #2.5 clk = ~clk;

    gid_top dut (
        .clk(clk), .rst(rst), .pin_in(pin_in), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_out(irq_out)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic wr(logic [5:0] a, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = A_FLG; reg_wdata = '0;
    endtask

    task automatic rd(logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
        reg_addr = A_FLG;
    endtask

    // mode: 0 edge fall, 1 edge rise, 2 level low, 3 level high,
    //       4 both (edge/rise bits), 5 both (level/low bits)
    task automatic run_case(int md, bit sy, int p);
        bit kind, pol, any, lvl, idle, exp1, exp2;
        bit [7:0] en, bitp;
        int lat;
        kind = (md == 2 || md == 3 || md == 5);
        pol  = (md == 1 || md == 3 || md == 4);
        any  = (md >= 4);
        lvl  = kind && !any;
        idle = lvl ? !pol : 1'b0;
        lat  = sy ? 4 : 2;
        en   = (p % 2 == 1) ? 8'h00 : 8'hFF;
        bitp = 8'(1 << p);
        wr(A_TYP, {24'h0, {8{kind}}});
        wr(A_POL, {24'h0, {8{pol}}});
        wr(A_ANY, {24'h0, {8{any}}});
        wr(A_SYN, {24'h0, {8{sy}}});
        wr(A_EN,  {24'h0, en});
        @(negedge clk);
        pin_in = {8{idle}};
        repeat (6) @(negedge clk);
        wr(A_CLR, 32'hFF);
        #1 chk("R7 idle clear", reg_rdata, 0);
        pin_in[p] = !idle;
        exp1 = any || lvl || pol;
        repeat (lat - 1) @(posedge clk);
        #1 chk(sy ? "R3 not yet" : "R2 not yet", reg_rdata, 0);
        @(posedge clk);
        #1 chk(sy ? "R3 first change R4 R5 R6" : "R2 first change R4 R5 R6",
               reg_rdata, exp1 ? {24'h0, bitp} : 0);
        chk("R9 request", {31'h0, irq_out}, {31'h0, exp1 && en[p]});
        if (lvl) begin
            wr(A_CLR, {24'h0, bitp});
            #1 chk("R5 clear while active", reg_rdata, {24'h0, bitp});
        end else begin
            wr(A_CLR, {24'h0, bitp});
            #1 chk("R7 clear after first", reg_rdata, 0);
        end
        @(negedge clk);
        pin_in[p] = idle;
        exp2 = lvl || any || !pol;
        repeat (lat + 1) @(posedge clk);
        #1 chk("R4 R5 R6 second change", reg_rdata, exp2 ? {24'h0, bitp} : 0);
        wr(A_CLR, {24'h0, ~bitp});
        #1 chk("R7 zero bits keep", reg_rdata, exp2 ? {24'h0, bitp} : 0);
        wr(A_CLR, {24'h0, bitp});
        #1 chk("R7 one bit clears", reg_rdata, 0);
    endtask

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R10 reset state
        rd(A_EN, d);  chk("R10 enable", d, 0);
        rd(A_TYP, d); chk("R10 type", d, 0);
        rd(A_SYN, d); chk("R10 sync", d, 0);
        rd(A_FLG, d); chk("R10 flags", d, 0);
        chk("R10 request", {31'h0, irq_out}, 0);
        // R1 register map
        wr(A_FLG, 32'hFF);
        rd(A_FLG, d); chk("R1 flag write ignored", d, 0);
        wr(A_EN,  32'hFFFF_FFA5); rd(A_EN, d);  chk("R1 enable", d, 32'hA5);
        wr(A_TYP, 32'hFFFF_FF3C); rd(A_TYP, d); chk("R1 type", d, 32'h3C);
        wr(A_POL, 32'hFFFF_FF5A); rd(A_POL, d); chk("R1 polarity", d, 32'h5A);
        wr(A_ANY, 32'hFFFF_FF81); rd(A_ANY, d); chk("R1 both-edge", d, 32'h81);
        wr(A_SYN, 32'hFFFF_FF7E); rd(A_SYN, d); chk("R1 sync", d, 32'h7E);
        rd(A_CLR, d);  chk("R1 clear reads zero", d, 0);
        rd(6'h00, d);  chk("R1 unmapped 00", d, 0);
        rd(6'h18, d);  chk("R1 unmapped 18", d, 0);
        // sweep
        for (int s = 0; s < 2; s++)
            for (int m = 0; m < 6; m++)
                for (int p = 0; p < 8; p++)
                    run_case(m, s[0], p);
        // R8 event and clear in the same cycle
        wr(A_TYP, 0); wr(A_POL, 32'hFF); wr(A_ANY, 0); wr(A_SYN, 0); wr(A_EN, 32'hFF);
        @(negedge clk); pin_in = 8'h00;
        repeat (4) @(negedge clk);
        wr(A_CLR, 32'hFF);
        pin_in[0] = 1'b1;
        repeat (3) @(negedge clk);
        #1 chk("R4 rise sets", reg_rdata, 32'h01);
        pin_in[0] = 1'b0;
        repeat (3) @(negedge clk);
        #1 chk("R4 fall ignored", reg_rdata, 32'h01);
        pin_in[0] = 1'b1;
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = A_CLR; reg_wdata = 32'h01;
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = A_FLG; reg_wdata = 0;
        #1 chk("R8 event beats clear", reg_rdata, 32'h01);
        chk("R9 request on", {31'h0, irq_out}, 1);
        wr(A_CLR, 32'h01);
        #1 chk("R8 later clear", reg_rdata, 0);
        chk("R9 request off", {31'h0, irq_out}, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule